// File: doc/BRIEF.md
# SPI Master with Word-Aligned Data Registers

This block is a memory-mapped SPI master. Software programs a mode word (enable, clock phase, clock idle level, bit order, internal loopback, word length, bit-rate prescale), writes one word to the transmit register, and the core shifts that word out on MOSI while it shifts in a word from MISO. At the end of the word the received bits are placed in the receive register, an event flag is raised and, if its mask bit is set, the interrupt line goes high. A register of active-low select lines, one bit per slave, is driven straight to the pins.

The word width runs from 4 to 16 bits, or 32 bits. Short words sit at fixed positions inside the 32-bit data registers, and those positions follow the bit order. Most-significant-bit-first words are left-justified for transmit and land with their LSB at bit 16 on receive. Least-significant-bit-first words are right-justified for transmit and land with their MSB at bit 15 on receive. Software can therefore move narrow words without a shift of its own.

Top module: `spi_aligned_master`

## Requirements
- R1: Register word indices are 0 mode, 1 event, 2 mask, 3 transmit, 4 receive, 5 select. After reset the mode word reads 0 (disabled), the event and mask words read 0, sclk is low and irq is low.
- R2: Mode bits [11:8] hold the word length minus one; the value 0 selects a 32-bit word. A 32-bit word uses the whole data register in both directions.
- R3: With mode bit 3 set (MSB first) and a word of 16 bits or fewer, transmit bit 31 is sent first and the received word is placed with its LSB at bit 16, all other receive bits zero.
- R4: With mode bit 3 clear (LSB first) and a word of 16 bits or fewer, transmit bit 0 is sent first and the received word is placed with its MSB at bit 15, all other receive bits zero.
- R5: Mode bit 2 sets the idle level of sclk. With mode bit 1 clear, MISO is sampled on the first edge of each bit; with it set, on the second edge. MOSI changes only on the other edge.
- R6: One sclk half period lasts 2*(P+1) clock cycles, where P is mode bits [19:16]; with mode bit 12 set it lasts 32*(P+1) cycles.
- R7: With mode bit 4 set, the receiver samples the block's own MOSI and ignores the MISO pin.
- R8: Event bit 1 (transmit not full) is set on the clock edge that accepts a transmit word; event bit 0 (receive not empty) is set on the clock edge that ends the word, 2*N half periods after acceptance for an N-bit word. Reading the receive register clears bit 0; writing 1 to an event bit clears it.
- R9: irq is high exactly when some event bit and its mask bit (same position in the mask word) are both set.
- R10: While mode bit 0 (enable) is set, a write to the mode word changes only the enable bit; all other fields keep their values.
- R11: A transmit write while disabled or while a word is in flight is ignored. While disabled the block does not shift and sclk stays at its idle level.
- R12: The select word resets to all ones; each of its bits drives one selN output directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word index |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effect on receive register) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| selN | output | NUM_SEL | Active-low slave selects |

## Verification
Words are sent in both bit orders at 4, 8, 12, 16 and 32 bits, so a wrong justification shows up as data in the wrong half of the receive register and a wrong serial order shows up in the bit stream captured on MOSI. Loopback runs are contrasted with runs where the bench answers with the inverse of MOSI on MISO, which separates an ignored loopback bit from a correct one. The two clock phases and both idle levels are paired with the external echo so that sampling on the wrong edge corrupts the received word, and the prescaler is checked by timing sclk half periods with and without the divide-by-16 bit.

// File: rtl/spi_aln_pkg.sv
package spi_aln_pkg;

  localparam int DW     = 32;
  localparam int PRE_W  = 4;
  localparam int LEN_W  = 4;
  localparam int HALF_W = 10;
  localparam int EDGE_W = 6;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd4;
  localparam logic [ADDR_W-1:0] A_SEL  = 3'd5;

  localparam int B_EN   = 0;
  localparam int B_CPHA = 1;
  localparam int B_CPOL = 2;
  localparam int B_MSB  = 3;
  localparam int B_LOOP = 4;
  localparam int B_LEN  = 8;
  localparam int B_DIV  = 12;
  localparam int B_PRE  = 16;

  typedef struct packed {
    logic load;
    logic abort;
    logic toggleClk;
    logic shiftOut;
    logic sampleIn;
    logic finish;
  } strobes_t;

  typedef struct packed {
    logic             en;
    logic             cpha;
    logic             cpol;
    logic             msbFirst;
    logic             loopEn;
    logic [LEN_W-1:0] lenField;
    logic             div16;
    logic [PRE_W-1:0] pre;
  } mode_t;

  function automatic mode_t modeFromWord(input logic [DW-1:0] w);
    mode_t m;
    m.en       = w[B_EN];
    m.cpha     = w[B_CPHA];
    m.cpol     = w[B_CPOL];
    m.msbFirst = w[B_MSB];
    m.loopEn   = w[B_LOOP];
    m.lenField = w[B_LEN +: LEN_W];
    m.div16    = w[B_DIV];
    m.pre      = w[B_PRE +: PRE_W];
    return m;
  endfunction

  function automatic logic [DW-1:0] modeToWord(input mode_t m);
    logic [DW-1:0] w;
    w = '0;
    w[B_EN]             = m.en;
    w[B_CPHA]           = m.cpha;
    w[B_CPOL]           = m.cpol;
    w[B_MSB]            = m.msbFirst;
    w[B_LOOP]           = m.loopEn;
    w[B_LEN +: LEN_W]   = m.lenField;
    w[B_DIV]            = m.div16;
    w[B_PRE +: PRE_W]   = m.pre;
    return w;
  endfunction

  function automatic logic [EDGE_W-1:0] wordBits(input logic [LEN_W-1:0] f);
    return (f == '0) ? EDGE_W'(32) : EDGE_W'(f) + EDGE_W'(1);
  endfunction

  function automatic logic [HALF_W-1:0] halfPeriod(input logic [PRE_W-1:0] p, input logic d16);
    logic [HALF_W-1:0] base;
    base = HALF_W'(p) + HALF_W'(1);
    return d16 ? (base << 5) : (base << 1);
  endfunction

endpackage

// File: rtl/spi_aln_regs.sv
module spi_aln_regs
  import spi_aln_pkg::*;
#(
  parameter int NUM_SEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic              busy,
  input  logic              finish,
  input  logic [DW-1:0]     rxHold,
  output mode_t             mode,
  output logic              startReq,
  output logic [1:0]        evtBits,
  output logic              irq,
  output logic [NUM_SEL-1:0] selN
);

  logic [1:0]         maskBits;
  logic [NUM_SEL-1:0] selReg;
  logic               evtWr;
  logic               rxRead;

  assign startReq = regWr && (regAddr == A_TX) && mode.en && !busy;
  assign evtWr    = regWr && (regAddr == A_EVT);
  assign rxRead   = regRd && (regAddr == A_RX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= '0;
      maskBits <= '0;
      selReg   <= '1;
      evtBits  <= '0;
    end else begin
      if (regWr && regAddr == A_MODE) begin
        if (mode.en) mode.en <= regWdata[B_EN];
        else         mode    <= modeFromWord(regWdata);
      end
      if (regWr && regAddr == A_MASK) maskBits <= regWdata[1:0];
      if (regWr && regAddr == A_SEL)  selReg   <= regWdata[NUM_SEL-1:0];
      if (finish)                                 evtBits[0] <= 1'b1;
      else if (rxRead || (evtWr && regWdata[0])) evtBits[0] <= 1'b0;
      if (startReq)                   evtBits[1] <= 1'b1;
      else if (evtWr && regWdata[1])  evtBits[1] <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_MODE:  regRdata = modeToWord(mode);
      A_EVT:   regRdata[1:0] = evtBits;
      A_MASK:  regRdata[1:0] = maskBits;
      A_RX:    regRdata = rxHold;
      A_SEL:   regRdata[NUM_SEL-1:0] = selReg;
      default: regRdata = '0;
    endcase
  end

  assign irq  = |(evtBits & maskBits);
  assign selN = selReg;

endmodule

// File: rtl/spi_aln_ctrl.sv
module spi_aln_ctrl
  import spi_aln_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpha,
  input  logic              startReq,
  input  logic [HALF_W-1:0] halfPer,
  input  logic [EDGE_W-1:0] bitsN,
  output strobes_t          st,
  output logic              busy
);

  logic [HALF_W-1:0] cnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic [EDGE_W-1:0] lastIdx;
  logic              edgeHit;
  logic              isSample;

  assign lastIdx  = {bitsN[EDGE_W-2:0], 1'b0} - EDGE_W'(1);
  assign edgeHit  = busy && enable && (cnt == halfPer - HALF_W'(1));
  assign isSample = (~edgeIdx[0]) ^ cpha;

  always_comb begin
    st           = '0;
    st.load      = startReq;
    st.abort     = busy && !enable;
    st.toggleClk = edgeHit;
    st.sampleIn  = edgeHit && isSample;
    st.shiftOut  = edgeHit && !isSample && (edgeIdx != lastIdx)
                   && !(cpha && edgeIdx == '0);
    st.finish    = edgeHit && (edgeIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      edgeIdx <= '0;
    end else if (!enable) begin
      busy    <= 1'b0;
      cnt     <= '0;
      edgeIdx <= '0;
    end else if (st.load) begin
      busy    <= 1'b1;
      cnt     <= '0;
      edgeIdx <= '0;
    end else if (busy) begin
      if (edgeHit) begin
        cnt <= '0;
        if (st.finish) busy <= 1'b0;
        else           edgeIdx <= edgeIdx + EDGE_W'(1);
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_aln_dpath.sv
module spi_aln_dpath
  import spi_aln_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DW-1:0]     txWord,
  input  logic              msbFirst,
  input  logic              cpol,
  input  logic              loopEn,
  input  logic [EDGE_W-1:0] bitsN,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DW-1:0]     rxHold
);

  logic [DW-1:0] txSh;
  logic [DW-1:0] rxAcc;
  logic [DW-1:0] rxAccNext;
  logic [DW-1:0] placed;
  logic          sclkLvl;
  logic          inBit;

  assign mosi  = msbFirst ? txSh[DW-1] : txSh[0];
  assign sclk  = cpol ^ sclkLvl;
  assign inBit = loopEn ? mosi : miso;

  always_comb begin
    rxAccNext = rxAcc;
    if (st.sampleIn)
      rxAccNext = msbFirst ? {rxAcc[DW-2:0], inBit} : {inBit, rxAcc[DW-1:1]};
  end

  always_comb begin
    if (bitsN == EDGE_W'(32)) placed = rxAccNext;
    else if (msbFirst)        placed = rxAccNext << (DW/2);
    else                      placed = rxAccNext >> (DW/2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxAcc   <= '0;
      rxHold  <= '0;
      sclkLvl <= 1'b0;
    end else if (st.abort) begin
      sclkLvl <= 1'b0;
    end else if (st.load) begin
      txSh    <= txWord;
      rxAcc   <= '0;
      sclkLvl <= 1'b0;
    end else begin
      rxAcc <= rxAccNext;
      if (st.toggleClk) sclkLvl <= ~sclkLvl;
      if (st.shiftOut)  txSh <= msbFirst ? (txSh << 1) : (txSh >> 1);
      if (st.finish)    rxHold <= placed;
    end
  end

endmodule

// File: rtl/spi_aligned_master.sv
module spi_aligned_master
  import spi_aln_pkg::*;
#(
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               irq,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] selN
);

  mode_t             mode;
  strobes_t          st;
  logic              busy;
  logic              startReq;
  logic [1:0]        evtBits;
  logic [DW-1:0]     rxHold;
  logic [EDGE_W-1:0] bitsN;
  logic [HALF_W-1:0] halfPer;

  assign bitsN   = wordBits(mode.lenField);
  assign halfPer = halfPeriod(mode.pre, mode.div16);

  spi_aln_regs #(.NUM_SEL(NUM_SEL)) uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .finish(st.finish),
    .rxHold(rxHold), .mode(mode), .startReq(startReq), .evtBits(evtBits),
    .irq(irq), .selN(selN)
  );

  spi_aln_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(mode.en), .cpha(mode.cpha),
    .startReq(startReq), .halfPer(halfPer), .bitsN(bitsN), .st(st), .busy(busy)
  );

  spi_aln_dpath uDpath (
    .clk(clk), .rstN(rstN), .st(st), .txWord(regWdata), .msbFirst(mode.msbFirst),
    .cpol(mode.cpol), .loopEn(mode.loopEn), .bitsN(bitsN), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxHold(rxHold)
  );

endmodule

// File: rtl/spi_aln_checker.sv
module spi_aln_checker
  import spi_aln_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input strobes_t   st,
  input logic       busy,
  input mode_t      mode,
  input logic [1:0] evtBits,
  input logic       sclk
);

  AST_TXNF_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> evtBits[1]); // R8

  AST_RXNE_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> evtBits[0]); // R8

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (mode.en && $past(mode.en)) |->
      $stable({mode.cpha, mode.cpol, mode.msbFirst, mode.loopEn,
               mode.lenField, mode.div16, mode.pre})); // R10

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == mode.cpol)); // R5

  AST_NO_SHIFT_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!mode.en && !$past(mode.en) && !$past(mode.en, 2) && $stable(mode.cpol))
      |-> $stable(sclk)); // R11

endmodule

bind spi_aligned_master spi_aln_checker uChk (
  .clk(clk), .rstN(rstN), .st(st), .busy(busy), .mode(mode),
  .evtBits(evtBits), .sclk(sclk)
);

// File: tb/spi_aligned_master_bench.sv
module spi_aligned_master_bench;

  localparam int NUM_SEL = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [2:0]         regAddr = '0;
  logic               regWr = 1'b0;
  logic               regRd = 1'b0;
  logic [31:0]        regWdata = '0;
  logic [31:0]        regRdata;
  logic               irq;
  logic               sclk;
  logic               mosi;
  logic               miso;
  logic [NUM_SEL-1:0] selN;

  int checks = 0;
  int failures = 0;
  logic [31:0] capBits = '0;
  int capCnt = 0;
  logic capCpol = 1'b0;
  logic capCpha = 1'b0;

  always #10 clk = ~clk;

  assign miso = ~mosi;

  spi_aligned_master #(.NUM_SEL(NUM_SEL)) u_spi_aligned_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .selN(selN)
  );

  always @(sclk) begin
    if (rstN && ((sclk !== capCpol) == (capCpha == 1'b0))) begin
      capBits = {capBits[30:0], mosi};
      capCnt  = capCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regW(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regR(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] mk(input bit en, input bit cpha, input bit cpol, input bit msb,
                                     input bit lp, input int len, input bit d16, input int pre);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = cpha; w[2] = cpol; w[3] = msb; w[4] = lp;
    w[11:8] = len[3:0]; w[12] = d16; w[19:16] = pre[3:0];
    return w;
  endfunction

  function automatic logic [31:0] revN(input logic [31:0] w, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = w[i];
    return r;
  endfunction

  task automatic waitRx();
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      peek(3'd1, d);
      if (d[0]) break;
    end
  endtask

  task automatic setup(input logic [31:0] m);
    regW(3'd0, m & ~32'h1);
    regW(3'd0, m);
    regW(3'd1, 32'h3);
    capCpol = m[2]; capCpha = m[1];
    capBits = '0; capCnt = 0;
  endtask

  // one word end to end, checking receive placement and serial order
  task automatic xfer(input string req, input logic [31:0] m, input logic [31:0] tx,
                      input logic [31:0] expRx, input logic [31:0] expCap, input int n);
    logic [31:0] d;
    setup(m);
    regW(3'd3, tx);
    waitRx();
    regR(3'd4, d);
    check(d == expRx, req, d, expRx);
    check(capCnt == n && capBits == expCap, req, capBits, expCap);
    check(sclk == m[2], {req, " R5 idle"}, {31'd0, sclk}, {31'd0, m[2]});
  endtask

  task automatic testReset();
    logic [31:0] d;
    check(selN == 4'hF, "R12 select reset", {28'd0, selN}, 32'hF);
    peek(3'd0, d); check(d == 0, "R1 mode reset", d, 0);
    peek(3'd1, d); check(d == 0, "R1 event reset", d, 0);
    check(sclk == 1'b0 && irq == 1'b0, "R1 sclk/irq reset", {30'd0, sclk, irq}, 0);
  endtask

  task automatic testTiming();
    logic [31:0] d;
    setup(mk(1, 0, 0, 1, 1, 7, 0, 0));
    regW(3'd3, 32'hA512_3456);
    peek(3'd1, d); check(d[1] == 1'b1, "R8 txnf on accept", d, 32'h2);
    repeat (31) @(posedge clk);
    @(negedge clk); peek(3'd1, d); check(d[0] == 1'b0, "R8 rxne not early", d, 32'h2);
    @(negedge clk); peek(3'd1, d); check(d == 32'h3, "R8 rxne at end", d, 32'h3);
    peek(3'd4, d); check(d == 32'h00A5_0000, "R3 R7 msb loop rx", d, 32'h00A5_0000);
    check(capCnt == 8 && capBits == 32'hA5, "R3 msb serial order", capBits, 32'hA5);
    regR(3'd4, d);
    peek(3'd1, d); check(d == 32'h2, "R8 rx read clears", d, 32'h2);
  endtask

  task automatic testRate(input string req, input logic [31:0] m, input int expHalf);
    logic lvl;
    int n;
    setup(m);
    regW(3'd3, 32'h0);
    lvl = sclk; n = 0;
    do begin @(posedge clk); #1; n++; end while (sclk == lvl && n < 1000);
    lvl = sclk; n = 0;
    do begin @(posedge clk); #1; n++; end while (sclk == lvl && n < 1000);
    check(n == expHalf, req, n, expHalf);
    waitRx();
  endtask

  task automatic testIrq();
    logic [31:0] d;
    regW(3'd2, 32'h1);
    xfer("R3", mk(1, 0, 0, 1, 1, 7, 0, 0), 32'h5A00_0000, 32'h005A_0000, 32'h5A, 8);
    // xfer read rx already; start another and check irq before reading
    setup(mk(1, 0, 0, 1, 1, 7, 0, 0));
    regW(3'd3, 32'h1100_0000);
    waitRx();
    @(negedge clk); check(irq == 1'b1, "R9 irq on rxne", {31'd0, irq}, 1);
    regR(3'd4, d);
    @(negedge clk); check(irq == 1'b0, "R9 irq after read", {31'd0, irq}, 0);
    regW(3'd2, 32'h2);
    @(negedge clk); check(irq == 1'b1, "R9 irq on txnf", {31'd0, irq}, 1);
    regW(3'd1, 32'h2);
    peek(3'd1, d); check(d == 0, "R8 write-one clear", d, 0);
    check(irq == 1'b0, "R9 irq after clear", {31'd0, irq}, 0);
    regW(3'd2, 32'h0);
  endtask

  task automatic testLock();
    logic [31:0] a, b, d;
    a = mk(1, 0, 0, 1, 1, 7, 0, 0);
    b = mk(1, 1, 1, 0, 0, 11, 1, 3);
    regW(3'd0, a & ~32'h1);
    regW(3'd0, a);
    regW(3'd0, b);
    peek(3'd0, d); check(d == a, "R10 fields locked", d, a);
    regW(3'd0, b & ~32'h1);
    peek(3'd0, d); check(d == (a & ~32'h1), "R10 only enable changes", d, a & ~32'h1);
    regW(3'd0, b & ~32'h1);
    peek(3'd0, d); check(d == (b & ~32'h1), "R10 disabled write takes", d, b & ~32'h1);
  endtask

  task automatic testIgnore();
    logic [31:0] d;
    regW(3'd0, mk(0, 0, 0, 1, 1, 7, 0, 0));
    regW(3'd1, 32'h3);
    capCpol = 1'b0; capCpha = 1'b0; capBits = '0; capCnt = 0;
    regW(3'd3, 32'hFF00_0000);
    repeat (100) @(posedge clk);
    @(negedge clk); peek(3'd1, d);
    check(d == 0 && capCnt == 0, "R11 disabled write ignored", d, 0);
    setup(mk(1, 0, 0, 1, 1, 7, 0, 0));
    regW(3'd3, 32'h3C00_0000);
    repeat (5) @(posedge clk);
    regW(3'd3, 32'hC300_0000);
    waitRx();
    repeat (80) @(posedge clk);
    regR(3'd4, d);
    check(d == 32'h003C_0000, "R11 busy write ignored", d, 32'h003C_0000);
    check(capCnt == 8, "R11 no second word", capCnt, 8);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    xfer("R4 lsb loop", mk(1, 0, 0, 0, 1, 7, 0, 0), 32'hFFFF_FF1E, 32'h0000_1E00, revN(32'h1E, 8), 8);
    xfer("R5 R3 cpol1 cpha1 ext", mk(1, 1, 1, 1, 0, 11, 0, 0), 32'hABC0_0000, 32'h0543_0000, 32'hABC, 12);
    xfer("R5 cpol1 cpha0 ext", mk(1, 0, 1, 1, 0, 15, 0, 0), 32'hBEEF_0000, 32'h4110_0000, 32'hBEEF, 16);
    xfer("R7 ext vs loop", mk(1, 1, 0, 1, 0, 7, 0, 0), 32'hA500_0000, 32'h005A_0000, 32'hA5, 8);
    xfer("R2 32-bit lsb", mk(1, 0, 0, 0, 1, 0, 0, 0), 32'h1234_5678, 32'h1234_5678, revN(32'h1234_5678, 32), 32);
    xfer("R2 R4 4-bit lsb", mk(1, 1, 0, 0, 1, 3, 0, 0), 32'h0000_0009, 32'h0000_9000, revN(32'h9, 4), 4);
    testRate("R6 prescale", mk(1, 0, 0, 1, 1, 3, 0, 1), 4);
    testRate("R6 divide by 16", mk(1, 0, 0, 1, 1, 3, 1, 0), 32);
    testIrq();
    testLock();
    testIgnore();
    regW(3'd5, 32'hA);
    @(negedge clk); check(selN == 4'hA, "R12 select drive", {28'd0, selN}, 32'hA);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule